// File: doc/BRIEF.md
# EEPROM Write Guard with Keyed Unlock

This block sits between a parallel write bus and the write port of an EEPROM core. Each write cycle arrives as an address, a data byte and a one-cycle strobe. The block decides whether that write reaches the array, and it drives a one-cycle commit pulse that carries the address and data. While the array is programming, the block holds a busy flag for a fixed number of clock cycles (the write-cycle time). No other write can start during that time.

The block also keeps a protection flag. When the flag is clear, an ordinary write goes straight through to the array. A three-write key opens the gate for exactly one write that follows it. The key is data AAh at address 5555h, then 55h at 2AAAh, then A0h at 5555h. That following write may target any address. It is committed, and once its write-cycle time has run out the protection flag becomes set. Only reset clears the flag. While it is set, only a keyed write ever reaches the array.

Top module: `ee_wr_guard`

## Requirements
- R1: In reset and on the first cycle after it, mem_we_o, busy_o and prot_o are 0. Reset clears a protection flag that was set.
- R2: With prot_o clear, a write that does not continue the key is committed. mem_we_o is high for exactly one cycle, in the cycle after the strobe is sampled, and mem_addr_o and mem_data_o equal the written address and data.
- R3: The key writes are AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h. Each write that matches the next expected step is absorbed: it gives no mem_we_o pulse and does not start busy_o.
- R4: The first write after a complete key is committed whatever its address and data. prot_o keeps its old value while busy_o is high, and becomes 1 on the same clock edge at which busy_o falls.
- R5: Once set, prot_o stays 1 until reset, whatever writes arrive.
- R6: With prot_o set, a write that is not preceded by a complete key gives no mem_we_o pulse and does not start busy_o.
- R7: A write that does not match the next expected key step returns the sequencer to idle, so the whole key has to be given again. With prot_o set, that write is discarded.
- R8: With prot_o clear, a write that breaks a partly entered key is committed as an ordinary write.
- R9: A write sampled while busy_o is high is ignored. It gives no pulse and neither advances nor resets the key sequencer.
- R10: busy_o rises together with mem_we_o and stays high for exactly TWC_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| mem_we_o | output | 1 | One-cycle commit pulse to the array |
| mem_addr_o | output | ADDR_W | Address of the committed write |
| mem_data_o | output | DATA_W | Data of the committed write |
| prot_o | output | 1 | Protection flag |
| busy_o | output | 1 | Write-cycle time in progress |

## Verification
A write strobe is sampled on edge N, and the commit pulse, its address and data, and the rise of busy all appear as registered outputs just after edge N. The bench drives the strobe on a falling edge and reads these results at the next falling edge, with no extra wait. After a commit it counts falling edges while busy stays high and expects exactly TWC_CYC of them. It watches the protection flag on each of those edges and requires it to change only at the sample where busy is first seen low. Absorbed, discarded and ignored writes are judged by the absence of the pulse at that same sample. They are also judged by what a later write does: a write sent after a key that was broken or ignored must come out as a plain commit and leave the flag clear.

// File: rtl/ee_guard_pkg.sv
package ee_guard_pkg;

    localparam int KEY_LEN = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2,
        SEQ_OPEN = 2'd3
    } seq_e;

    // address expected at key step i
    function automatic logic [15:0] key_addr(input int i);
        case (i)
            1:       key_addr = 16'h2AAA;
            default: key_addr = 16'h5555;
        endcase
    endfunction

    // data expected at key step i
    function automatic logic [7:0] key_data(input int i);
        case (i)
            0:       key_data = 8'hAA;
            1:       key_data = 8'h55;
            default: key_data = 8'hA0;
        endcase
    endfunction

endpackage

// File: rtl/ee_key_match.sv
module ee_key_match
    import ee_guard_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [KEY_LEN-1:0] hit_o
);

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_step
        localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(key_addr(g));
        localparam logic [DATA_W-1:0] STEP_DATA = DATA_W'(key_data(g));
        assign hit_o[g] = (addr_i == STEP_ADDR) && (data_i == STEP_DATA);
    end

endmodule

// File: rtl/ee_unlock_fsm.sv
module ee_unlock_fsm
    import ee_guard_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,     // already gated by busy
    input  logic [KEY_LEN-1:0] hit_i,
    input  logic               prot_i,
    output logic               commit_o,
    output logic               keyed_o
);

    typedef struct packed {
        seq_e seq;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d        = q;
        commit_o = 1'b0;
        keyed_o  = 1'b0;
        if (wr_i) begin
            unique case (q.seq)
                SEQ_IDLE: begin
                    if (hit_i[0]) d.seq = SEQ_ONE;
                    else commit_o = !prot_i;
                end
                SEQ_ONE: begin
                    if (hit_i[1]) d.seq = SEQ_TWO;
                    else begin
                        d.seq    = SEQ_IDLE;
                        commit_o = !prot_i;
                    end
                end
                SEQ_TWO: begin
                    if (hit_i[2]) d.seq = SEQ_OPEN;
                    else begin
                        d.seq    = SEQ_IDLE;
                        commit_o = !prot_i;
                    end
                end
                SEQ_OPEN: begin
                    d.seq    = SEQ_IDLE;
                    commit_o = 1'b1;
                    keyed_o  = 1'b1;
                end
                default: d.seq = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '{seq: SEQ_IDLE};
        else         q <= d;
    end

    AST_SEQ_HOLD_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(q.seq)); // R9

    AST_OPEN_AFTER_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.seq == SEQ_OPEN && $past(q.seq) != SEQ_OPEN) |-> $past(q.seq) == SEQ_TWO); // R3

endmodule

// File: rtl/ee_wc_timer.sv
module ee_wc_timer #(
    parameter int TWC_CYC = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic keyed_i,
    output logic busy_o,
    output logic prot_o
);

    localparam int CNT_W = $clog2(TWC_CYC + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             arm;
        logic             prot;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(TWC_CYC - 1);
            d.arm  = keyed_i;
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.arm  = 1'b0;
                if (q.arm) d.prot = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_o = q.busy;
    assign prot_o = q.prot;

    // run-length counter used only by the checks below
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> run_q == (CNT_W+1)'(TWC_CYC)); // R10

    AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && start_i)); // R9

    AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prot_o |=> prot_o); // R5

    AST_PROT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(prot_o) |-> $fell(busy_o)); // R4

endmodule

// File: rtl/ee_wr_guard.sv
module ee_wr_guard
    import ee_guard_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int TWC_CYC = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              prot_o,
    output logic              busy_o
);

    logic [KEY_LEN-1:0] hit;
    logic               wr_ok, commit, keyed;

    assign wr_ok = wr_i && !busy_o;

    ee_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_match (
        .addr_i (addr_i),
        .data_i (data_i),
        .hit_o  (hit)
    );

    ee_unlock_fsm i_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_ok),
        .hit_i    (hit),
        .prot_i   (prot_o),
        .commit_o (commit),
        .keyed_o  (keyed)
    );

    ee_wc_timer #(.TWC_CYC(TWC_CYC)) i_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (commit),
        .keyed_i (keyed),
        .busy_o  (busy_o),
        .prot_o  (prot_o)
    );

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t q, d;

    always_comb begin
        d    = q;
        d.we = commit;
        if (commit) begin
            d.addr = addr_i;
            d.data = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign mem_we_o   = q.we;
    assign mem_addr_o = q.addr;
    assign mem_data_o = q.data;

    AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |=> !mem_we_o); // R2

    AST_WE_WITH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> $rose(busy_o)); // R10

    AST_BUSY_WR_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && wr_i) |=> !mem_we_o); // R9

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (!mem_we_o && !busy_o && !prot_o)); // R1

endmodule

// File: tb/test_ee_wr_guard.sv
module test_ee_wr_guard;

    localparam int AW  = 15;
    localparam int DW  = 8;
    localparam int TWC = 12;
    localparam int NV  = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          mem_we, prot, busy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    always #5 clk = ~clk;

    ee_wr_guard #(.ADDR_W(AW), .DATA_W(DW), .TWC_CYC(TWC)) i_ee_wr_guard (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
        .prot_o(prot), .busy_o(busy)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one strobe; returns the pulse seen right after the sampling edge
    task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, output bit we_seen);
        @(negedge clk);
        wr = 1'b1; addr = a; data = d;
        @(negedge clk);
        wr = 1'b0;
        we_seen = mem_we;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit exp_we, input string req);
        bit we_seen, pv, held, second_we;
        int cnt;
        pulse(a, d, we_seen);
        chk(we_seen == exp_we, req, "commit pulse", int'(we_seen), int'(exp_we));
        if (exp_we && we_seen) begin
            chk(mem_addr == a, req, "commit address", int'(mem_addr), int'(a));
            chk(mem_data == d, req, "commit data", int'(mem_data), int'(d));
            pv = prot; held = 1'b1; cnt = 0; second_we = 1'b0;
            while (busy && cnt < 4 * TWC) begin
                cnt++;
                if (prot != pv) held = 1'b0;
                @(negedge clk);
                if (cnt == 1) second_we = mem_we;
            end
            chk(cnt == TWC, "R10", "busy cycles", cnt, TWC);
            chk(held, "R4", "prot steady while busy", int'(held), 1);
            chk(!second_we, "R2", "pulse width", int'(second_we), 0);
        end else begin
            chk(!busy, req, "busy after non-commit", int'(busy), 0);
        end
    endtask

    // vector: addr, data, expected pulse, expected prot afterwards
    localparam logic [AW+DW+1:0] VEC [NV] = '{
        {15'h0100, 8'h11, 1'b1, 1'b0},  // R2 plain write, unprotected
        {15'h5555, 8'hAA, 1'b0, 1'b0},  // R3 key step 1
        {15'h2AAA, 8'h55, 1'b0, 1'b0},  // R3 key step 2
        {15'h5555, 8'hA0, 1'b0, 1'b0},  // R3 key step 3
        {15'h1234, 8'h5A, 1'b1, 1'b1},  // R4 keyed write sets protection
        {15'h0200, 8'h22, 1'b0, 1'b1},  // R6 lone write blocked
        {15'h5555, 8'hAA, 1'b0, 1'b1},
        {15'h2AAA, 8'h55, 1'b0, 1'b1},
        {15'h5555, 8'hA0, 1'b0, 1'b1},
        {15'h0777, 8'hC3, 1'b1, 1'b1},  // R4 keyed write while protected
        {15'h5555, 8'hAA, 1'b0, 1'b1},
        {15'h2AAA, 8'h12, 1'b0, 1'b1},  // R7 wrong data, discarded
        {15'h5555, 8'hA0, 1'b0, 1'b1},  // R7 not a step-1 match, discarded
        {15'h0300, 8'h33, 1'b0, 1'b1}   // R7 sequencer not open
    };

    function automatic string vtag(input int i);
        case (i)
            0:                vtag = "R2";
            1, 2, 3, 6, 7, 8: vtag = "R3";
            4, 9:             vtag = "R4";
            5:                vtag = "R6";
            default:          vtag = "R7";
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit ew, ep, ws;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!mem_we && !busy && !prot, "R1", "outputs in reset", {mem_we, busy, prot}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_we && !busy && !prot, "R1", "outputs after reset", {mem_we, busy, prot}, 0);

        for (int i = 0; i < NV; i++) begin
            {a, d, ew, ep} = VEC[i];
            do_write(a, d, ew, vtag(i));
            chk(prot == ep, "R5", $sformatf("prot after vector %0d", i), int'(prot), int'(ep));
        end

        // R1 reset clears protection
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!prot, "R1", "reset clears prot", int'(prot), 0);
        rst_n = 1'b1;

        // R8 broken key while unprotected commits the breaking write
        do_write(15'h5555, 8'hAA, 1'b0, "R3");
        do_write(15'h0400, 8'h44, 1'b1, "R8");
        chk(!prot, "R8", "prot stays clear", int'(prot), 0);

        // R9 key writes during busy are ignored
        pulse(15'h0500, 8'h55, ws);
        chk(ws, "R9", "plain commit before busy window", int'(ws), 1);
        pulse(15'h5555, 8'hAA, ws);
        chk(!ws, "R9", "busy write 1 pulse", int'(ws), 0);
        pulse(15'h2AAA, 8'h55, ws);
        chk(!ws, "R9", "busy write 2 pulse", int'(ws), 0);
        pulse(15'h5555, 8'hA0, ws);
        chk(!ws, "R9", "busy write 3 pulse", int'(ws), 0);
        while (busy) @(negedge clk);
        do_write(15'h0600, 8'h66, 1'b1, "R9");
        chk(!prot, "R9", "ignored key left prot clear", int'(prot), 0);

        // R4 timing of protection after a keyed write
        do_write(15'h5555, 8'hAA, 1'b0, "R3");
        do_write(15'h2AAA, 8'h55, 1'b0, "R3");
        do_write(15'h5555, 8'hA0, 1'b0, "R3");
        do_write(15'h0700, 8'h77, 1'b1, "R4");
        chk(prot, "R4", "prot set after write-cycle time", int'(prot), 1);
        do_write(15'h0800, 8'h88, 1'b0, "R6");
        chk(prot, "R5", "prot still set", int'(prot), 1);

        finish_run();
    end

endmodule